// File: doc/BRIEF.md
# Analog Channel Scan Sequencer

This block supplies the multiplexer channel address for every conversion of a sixteen-input acquisition front end. It can hold one fixed input, or it can step automatically through a range that always has channel 0 at one end and a programmed limit channel at the other. The scan can run upward (0 up to the limit, then back to 0) or downward (limit down to 0, then back to the limit).

The host drives a command write that carries a channel field and a fixed-channel bit. It drives a separate direction write. A command write with the fixed-channel bit set selects that channel and also stores it as the scan limit. A command write that follows it with the bit cleared starts scanning. Each conversion-start strobe moves the address one step after the conversion has used the current channel. A clear-acquisition strobe restarts the scan at its first channel.

Top module: `scan_seq_top`

## Requirements
- R1: After reset the channel output is 0, the sequencer is in single-channel mode, and the direction register holds 0 (0 = downward order, 1 = upward order).
- R2: A command write with the fixed-channel bit at 1 makes the channel output equal the written 4-bit field on the next cycle. The output then stays there across any number of conversion strobes and clear strobes.
- R3: A command write with the fixed-channel bit at 0 starts scanning only when the previous command write had the bit at 1. The channel field of this starting write is ignored. Any other write with the bit at 0 has no effect, whether the block is in reset-state single mode or already scanning.
- R4: In the upward order the scan starts at channel 0. Each conversion strobe adds 1. From the limit channel the address wraps to 0.
- R5: In the downward order the scan starts at the limit channel. Each conversion strobe subtracts 1. From channel 0 the address reloads the limit.
- R6: The channel output does not change in the cycle that carries the conversion strobe. It takes its new value one cycle after that strobe.
- R7: The direction register can be written at any time. Its value is captured only when a scan starts. Writing it during a scan does not change the running order, and it does not change the first channel that a clear strobe restores.
- R8: In scan mode a clear strobe returns the address to the first channel of the running order (0 for upward, the limit for downward). If a clear strobe and a conversion strobe arrive together, the clear strobe wins.
- R9: A command write with the fixed-channel bit at 1 during a scan stops the scan, and the output holds the new field.
- R10: With a limit of 0 the scan stays on channel 0 in both orders.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| cmd_wr_i | input | 1 | Command write strobe |
| cmd_chan_i | input | 4 | Channel field of the command write |
| cmd_fix_i | input | 1 | Fixed-channel bit of the command write |
| dir_wr_i | input | 1 | Direction register write strobe |
| dir_up_i | input | 1 | Direction value (1 = upward) |
| conv_start_i | input | 1 | Conversion-start strobe |
| acq_clr_i | input | 1 | Clear-acquisition strobe |
| mux_chan_o | output | 4 | Multiplexer channel address |

## Verification
Several properties are checked on every cycle. The address never exceeds the limit while scanning. The address holds whenever no scan is running and no command changes it. Each stepping strobe gives an increment, a decrement or the correct wrap. Scanning can begin only right after a clearing command write. The captured order stays stable during a scan. Other behaviour can only be shown by the bench's scenarios: the full two-write arming sequence, the ignored field and the ignored stray writes, the reset direction, the priority of clear over step, and the exact channel order over every limit in both directions. The bench covers these with an exhaustive sweep of all sixteen limits in both orders.

// File: rtl/scan_seq_pkg.sv
`timescale 1ns/1ps
package scan_seq_pkg;
  // Sequencer operating mode
  typedef enum logic [1:0] {
    SEQ_SINGLE = 2'd0,  // fixed channel, no scan limit armed
    SEQ_LOADED = 2'd1,  // fixed channel, limit loaded, waiting for arm write
    SEQ_SCAN   = 2'd2   // automatic scanning
  } seq_mode_e;
endpackage

// File: rtl/scan_cmd_ctrl.sv
`timescale 1ns/1ps
module scan_cmd_ctrl
  import scan_seq_pkg::*;
#(
  parameter int CW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cmd_wr_i,
  input  logic [CW-1:0] cmd_chan_i,
  input  logic          cmd_fix_i,
  input  logic          dir_wr_i,
  input  logic          dir_up_i,
  output logic          load_evt_o,
  output logic          arm_evt_o,
  output logic          scan_active_o,
  output logic          scan_up_o,
  output logic          pend_up_o,
  output logic [CW-1:0] limit_o
);
  seq_mode_e     mode_q;
  logic [CW-1:0] limit_q;
  logic          pend_up_q;
  logic          scan_up_q;

  // named events for the address counter and the assertions
  assign load_evt_o    = cmd_wr_i & cmd_fix_i;
  assign arm_evt_o     = cmd_wr_i & ~cmd_fix_i & (mode_q == SEQ_LOADED);
  assign scan_active_o = (mode_q == SEQ_SCAN);
  assign scan_up_o     = scan_up_q;
  assign pend_up_o     = pend_up_q;
  assign limit_o       = limit_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      mode_q    <= SEQ_SINGLE;
      limit_q   <= '0;
      pend_up_q <= 1'b0;
      scan_up_q <= 1'b0;
    end else begin
      if (dir_wr_i) pend_up_q <= dir_up_i;
      if (load_evt_o) begin
        mode_q  <= SEQ_LOADED;
        limit_q <= cmd_chan_i;
      end else if (arm_evt_o) begin
        mode_q    <= SEQ_SCAN;
        scan_up_q <= pend_up_q;
      end
    end
  end

  AST_SCAN_NEEDS_ARM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(scan_active_o) |-> $past(cmd_wr_i && !cmd_fix_i)); // R3

  AST_ORDER_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (scan_active_o && !cmd_wr_i) |=> (scan_active_o && $stable(scan_up_q))); // R7

  AST_FIX_STOPS_SCAN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_evt_o |=> !scan_active_o); // R9
endmodule

// File: rtl/scan_addr_ctr.sv
`timescale 1ns/1ps
module scan_addr_ctr #(
  parameter int CW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_evt_i,
  input  logic [CW-1:0] load_chan_i,
  input  logic          arm_evt_i,
  input  logic          pend_up_i,
  input  logic          scan_active_i,
  input  logic          scan_up_i,
  input  logic [CW-1:0] limit_i,
  input  logic          conv_i,
  input  logic          clr_i,
  output logic [CW-1:0] addr_o
);
  logic [CW-1:0] addr_q;
  logic          restart_evt;
  logic          step_evt;

  function automatic logic [CW-1:0] first_chan(input logic up, input logic [CW-1:0] lim);
    return up ? '0 : lim;
  endfunction

  function automatic logic [CW-1:0] next_chan(input logic up, input logic [CW-1:0] a,
                                              input logic [CW-1:0] lim);
    if (up) return (a == lim) ? '0 : a + 1'b1;
    else    return (a == '0) ? lim : a - 1'b1;
  endfunction

  assign restart_evt = scan_active_i & clr_i & ~load_evt_i;
  assign step_evt    = scan_active_i & conv_i & ~clr_i & ~load_evt_i;

  always_ff @(posedge clk_i) begin
    if (!rst_ni)          addr_q <= '0;
    else if (load_evt_i)  addr_q <= load_chan_i;
    else if (arm_evt_i)   addr_q <= first_chan(pend_up_i, limit_i);
    else if (restart_evt) addr_q <= first_chan(scan_up_i, limit_i);
    else if (step_evt)    addr_q <= next_chan(scan_up_i, addr_q, limit_i);
  end

  assign addr_o = addr_q;

  AST_WITHIN_LIMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    scan_active_i |-> (addr_q <= limit_i)); // R4

  AST_HOLD_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!scan_active_i && !load_evt_i && !arm_evt_i) |=> $stable(addr_q)); // R2

  AST_UP_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_evt && scan_up_i && addr_q != limit_i) |=> (addr_q == CW'($past(addr_q) + 1'b1))); // R4

  AST_UP_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_evt && scan_up_i && addr_q == limit_i) |=> (addr_q == '0)); // R4

  AST_DOWN_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_evt && !scan_up_i && addr_q != '0) |=> (addr_q == CW'($past(addr_q) - 1'b1))); // R5

  AST_DOWN_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_evt && !scan_up_i && addr_q == '0) |=> (addr_q == $past(limit_i))); // R5

  AST_CLR_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_evt |=> (addr_q == (scan_up_i ? '0 : limit_i))); // R8
endmodule

// File: rtl/scan_seq_top.sv
`timescale 1ns/1ps
module scan_seq_top #(
  parameter int NUM_CH = 16,
  localparam int CW = $clog2(NUM_CH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cmd_wr_i,
  input  logic [CW-1:0] cmd_chan_i,
  input  logic          cmd_fix_i,
  input  logic          dir_wr_i,
  input  logic          dir_up_i,
  input  logic          conv_start_i,
  input  logic          acq_clr_i,
  output logic [CW-1:0] mux_chan_o
);
  logic          load_evt, arm_evt, scan_active, scan_up, pend_up;
  logic [CW-1:0] limit;

  scan_cmd_ctrl #(.CW(CW)) cmd_i (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .cmd_wr_i      (cmd_wr_i),
    .cmd_chan_i    (cmd_chan_i),
    .cmd_fix_i     (cmd_fix_i),
    .dir_wr_i      (dir_wr_i),
    .dir_up_i      (dir_up_i),
    .load_evt_o    (load_evt),
    .arm_evt_o     (arm_evt),
    .scan_active_o (scan_active),
    .scan_up_o     (scan_up),
    .pend_up_o     (pend_up),
    .limit_o       (limit)
  );

  scan_addr_ctr #(.CW(CW)) addr_i (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .load_evt_i    (load_evt),
    .load_chan_i   (cmd_chan_i),
    .arm_evt_i     (arm_evt),
    .pend_up_i     (pend_up),
    .scan_active_i (scan_active),
    .scan_up_i     (scan_up),
    .limit_i       (limit),
    .conv_i        (conv_start_i),
    .clr_i         (acq_clr_i),
    .addr_o        (mux_chan_o)
  );

  AST_OUT_CHANGES_LATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cmd_wr_i && !conv_start_i && !acq_clr_i) |=> $stable(mux_chan_o)); // R6
endmodule

// File: tb/scan_seq_top_tb_top.sv
`timescale 1ns/1ps
module scan_seq_top_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_wr = 1'b0, cmd_fix = 1'b0, dir_wr = 1'b0, dir_up = 1'b0;
  logic       conv = 1'b0, clr = 1'b0;
  logic [3:0] cmd_chan = 4'd0;
  logic [3:0] mux_chan;

  int checks = 0;
  int failures = 0;
  // bench model of the requirements
  int e_ch = 0, e_mode = 0, e_lim = 0, e_dirq = 0, e_sdir = 0;

  always #2.5 clk = ~clk;

  scan_seq_top dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cmd_wr_i(cmd_wr), .cmd_chan_i(cmd_chan),
    .cmd_fix_i(cmd_fix), .dir_wr_i(dir_wr), .dir_up_i(dir_up),
    .conv_start_i(conv), .acq_clr_i(clr), .mux_chan_o(mux_chan)
  );

  task automatic check(input int got, input int exp, input string tag);
    checks++;
    if (got != exp) begin
      failures++;
      $display("FAIL %s: got %0d expected %0d at %0t", tag, got, exp, $time);
    end
  endtask

  // one cycle of stimulus; model updated from the requirements
  task automatic cyc(input bit cw, input int ch, input bit fx, input bit dw, input bit dv,
                     input bit cv, input bit cl, input string tag);
    @(negedge clk);
    cmd_wr = cw; cmd_chan = 4'(ch); cmd_fix = fx; dir_wr = dw; dir_up = dv; conv = cv; clr = cl;
    if (cv) check(int'(mux_chan), e_ch, "R6 channel held during strobe");
    if (cw && fx) begin e_mode = 1; e_lim = ch; e_ch = ch; end
    else if (cw && e_mode == 1) begin
      e_mode = 2; e_sdir = e_dirq; e_ch = e_sdir ? 0 : e_lim;
    end else if (cl && e_mode == 2) e_ch = e_sdir ? 0 : e_lim;
    else if (cv && e_mode == 2)
      e_ch = e_sdir ? (e_ch + 1) % (e_lim + 1) : (e_ch + e_lim) % (e_lim + 1);
    if (dw) e_dirq = dv;
    @(negedge clk);
    cmd_wr = 0; dir_wr = 0; conv = 0; clr = 0;
    check(int'(mux_chan), e_ch, tag);
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    e_ch = 0; e_mode = 0; e_lim = 0; e_dirq = 0; e_sdir = 0;
  endtask

  initial begin
    #(200000 * 5);
    failures++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    do_reset();
    check(int'(mux_chan), 0, "R1 reset channel");
    cyc(0, 0, 0, 0, 0, 1, 0, "R1 single mode holds 0");
    // R3: stray clear-bit write in reset-state single mode is ignored
    cyc(1, 9, 0, 0, 0, 0, 0, "R3 stray write ignored");
    cyc(0, 0, 0, 0, 0, 1, 0, "R3 still single after stray write");
    // R1/R7: reset direction is downward
    cyc(1, 3, 1, 0, 0, 0, 0, "R2 load 3");
    cyc(1, 12, 0, 0, 0, 0, 0, "R1 reset order downward starts at limit");
    // exhaustive sweep: both orders, every limit
    for (int d = 0; d < 2; d++) begin
      for (int lim = 0; lim < 16; lim++) begin
        cyc(0, 0, 0, 1, d[0], 0, 0, "R7 direction write");
        cyc(1, lim, 1, 0, 0, 0, 0, "R2 fixed field shown");
        cyc(0, 0, 0, 0, 0, 1, 0, "R2 fixed field held");
        cyc(0, 0, 0, 0, 0, 0, 1, "R2 clear ignored in single mode");
        cyc(1, lim ^ 5, 0, 0, 0, 0, 0, "R3 arm, field ignored");
        for (int s = 0; s < 2 * (lim + 1) + 1; s++)
          cyc(0, 0, 0, 0, 0, 1, 0, (lim == 0) ? "R10 limit 0 scan" : (d ? "R4 up scan" : "R5 down scan"));
      end
    end
    // R3: clear-bit write during a scan is ignored
    cyc(0, 0, 0, 1, 1, 0, 0, "R7 set up");
    cyc(1, 5, 1, 0, 0, 0, 0, "R2 load 5");
    cyc(1, 5, 0, 0, 0, 0, 0, "R4 up start");
    cyc(0, 0, 0, 0, 0, 1, 0, "R4 step");
    cyc(0, 0, 0, 0, 0, 1, 0, "R4 step");
    cyc(1, 14, 0, 0, 0, 0, 0, "R3 write during scan ignored");
    cyc(0, 0, 0, 0, 0, 1, 0, "R3 scan continues");
    // R7: direction change mid-scan has no effect
    cyc(0, 0, 0, 1, 0, 0, 0, "R7 dir write mid-scan");
    cyc(0, 0, 0, 0, 0, 1, 0, "R7 order kept upward");
    cyc(0, 0, 0, 0, 0, 0, 1, "R7 clear uses running order");
    cyc(0, 0, 0, 0, 0, 1, 0, "R4 step after clear");
    cyc(0, 0, 0, 0, 0, 1, 1, "R8 clear beats conversion");
    // re-arm picks up new direction (downward)
    cyc(1, 5, 1, 0, 0, 0, 0, "R2 reload 5");
    cyc(1, 0, 0, 0, 0, 0, 0, "R7 new order downward");
    cyc(0, 0, 0, 0, 0, 1, 0, "R5 step");
    cyc(0, 0, 0, 0, 0, 1, 1, "R8 clear to limit");
    // R9: fixed write during scan stops it
    cyc(0, 0, 0, 0, 0, 1, 0, "R5 step");
    cyc(1, 11, 1, 0, 0, 0, 0, "R9 fixed write in scan");
    cyc(0, 0, 0, 0, 0, 1, 0, "R9 held after stop");
    cyc(0, 0, 0, 0, 0, 0, 1, "R9 clear no effect");
    // R3: after reset a clear-bit write directly is still ignored
    do_reset();
    check(int'(mux_chan), 0, "R1 reset channel again");
    cyc(1, 7, 0, 0, 0, 0, 0, "R3 stray write after reset");
    cyc(0, 0, 0, 0, 0, 1, 0, "R3 no scan after stray write");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule